// File: doc/BRIEF.md
# Stack Call/Return and Push/Pull Sequencer

This block carries out the stack-related commands of an 8-bit processor core: subroutine call and return, software break and return from interrupt, and single-byte push and pull of the accumulator or the flag byte. It owns the 8-bit stack pointer. The stack occupies memory page 0x01. The block drives a byte-wide memory port with one access per cycle. Reads are combinational: read data belongs to the address driven in the same cycle.

The core offers a command together with the current program counter, the call target, the accumulator and the flags. The block captures them when it accepts the command. It then steps through its memory accesses and shows the updated program counter, flags, accumulator and stack pointer on its outputs. The cycle in which it makes its final access is marked by a one-cycle done pulse.

Top module: `stk_seq`

## Requirements
- R1: Command codes on `cmd_op` are 0 break, 1 call, 2 return-from-subroutine, 3 return-from-interrupt, 4 push accumulator, 5 push flags, 6 pull accumulator, 7 pull flags. A command is taken only when `cmd_valid` is high in a cycle where `busy` is low. While `busy` is high, `cmd_valid`, `cmd_op` and the data inputs are ignored, and `mem_we` is never high while idle.
- R2: Every stack address is 0x0100 plus an 8-bit offset. A push writes at 0x0100+S and then lowers S by one. A pull first raises S by one and then reads at 0x0100+S. S wraps modulo 256 and resets to 0xFF.
- R3: Push accumulator writes the captured `a_in` in one cycle.
- R4: Push flags writes the captured `p_in` unchanged in one cycle.
- R5: Pull accumulator loads A with the pulled byte. It sets flag bit 7 to the byte's bit 7 and flag bit 1 to one exactly when the byte is zero, and leaves all other flag bits as captured.
- R6: Pull flags replaces all eight flag bits with the pulled byte.
- R7: Call writes the high byte and then the low byte of (`pc_in` − 1), then sets the program counter to `target`, in two cycles.
- R8: Return-from-subroutine pulls the low byte and then the high byte, and sets the program counter to that word plus one, modulo 2^16, in two cycles.
- R9: Return-from-interrupt pulls the flags, then the low byte, then the high byte. The program counter is set to that word with no increment, in three cycles.
- R10: Break writes the high byte of `pc_in`, then its low byte, then the captured flags. It reads 0xFFFE as the low byte and then 0xFFFF as the high byte of the new program counter, and sets flag bit 4. This takes five cycles, and the vector addresses are never written.
- R11: `done` is high for exactly the cycle of the final access. The results appear on the outputs after that clock edge, when `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code |
| pc_in | input | 16 | Address of the next instruction |
| target | input | 16 | Call destination |
| a_in | input | 8 | Accumulator value |
| p_in | input | 8 | Flag byte |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Final access of the command |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data, same cycle |
| pc_out | output | 16 | Program counter result |
| p_out | output | 8 | Flag result |
| a_out | output | 8 | Accumulator result |
| s_out | output | 8 | Stack pointer |

## Verification
The bench pulls from S=0xFF and then pushes from S=0x00. A design that does not wrap the stack pointer, or that reads before incrementing, would touch the wrong address or lose page 0x01. A call followed by a return, and a break followed by a return-from-interrupt, both check the exact byte order and the off-by-one rules. A return that skipped the increment, or an interrupt return that added one, would land one byte off. A return from 0xFFFF checks 16-bit wrap. A command held on the inputs while the block is busy checks that nothing is re-captured or started twice, which would otherwise show up as extra writes or a changed accumulator.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    OP_BRK = 3'd0, OP_JSR = 3'd1, OP_RTS = 3'd2, OP_RTI = 3'd3,
    OP_PHA = 3'd4, OP_PHP = 3'd5, OP_PLA = 3'd6, OP_PLP = 3'd7
  } stk_op_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_RET_HI, SRC_RET_LO, SRC_FLAGS, SRC_ACC
  } wsrc_e;

  typedef enum logic [2:0] {
    DST_NONE, DST_PC_LO, DST_PC_HI, DST_FLAGS, DST_ACC
  } rdst_e;

  typedef struct packed {
    logic  act;
    logic  wr;
    logic  vec;
    logic  vhi;
    wsrc_e src;
    rdst_e dst;
    logic  last;
  } step_t;
endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_valid,
  input  stk_op_e cmd_op,
  output logic    accept,
  output logic    busy,
  output stk_op_e op_q,
  output step_t   step
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e               state_q, state_d;
  logic [STEP_W-1:0] cnt_q, cnt_d;

  assign accept = cmd_valid && (state_q == ST_IDLE);
  assign busy   = (state_q == ST_RUN);

  always_comb begin
    step = '0;
    if (state_q == ST_RUN) begin
      step.act = 1'b1;
      unique case (op_q)
        OP_BRK: begin
          unique case (cnt_q)
            3'd0:    begin step.wr = 1'b1; step.src = SRC_RET_HI; end
            3'd1:    begin step.wr = 1'b1; step.src = SRC_RET_LO; end
            3'd2:    begin step.wr = 1'b1; step.src = SRC_FLAGS; end
            3'd3:    begin step.vec = 1'b1; step.dst = DST_PC_LO; end
            default: begin step.vec = 1'b1; step.vhi = 1'b1;
                           step.dst = DST_PC_HI; step.last = 1'b1; end
          endcase
        end
        OP_JSR: begin
          step.wr   = 1'b1;
          step.src  = (cnt_q == 3'd0) ? SRC_RET_HI : SRC_RET_LO;
          step.last = (cnt_q != 3'd0);
        end
        OP_RTS: begin
          step.dst  = (cnt_q == 3'd0) ? DST_PC_LO : DST_PC_HI;
          step.last = (cnt_q != 3'd0);
        end
        OP_RTI: begin
          unique case (cnt_q)
            3'd0:    step.dst = DST_FLAGS;
            3'd1:    step.dst = DST_PC_LO;
            default: begin step.dst = DST_PC_HI; step.last = 1'b1; end
          endcase
        end
        OP_PHA: begin step.wr = 1'b1; step.src = SRC_ACC;   step.last = 1'b1; end
        OP_PHP: begin step.wr = 1'b1; step.src = SRC_FLAGS; step.last = 1'b1; end
        OP_PLA: begin step.dst = DST_ACC;   step.last = 1'b1; end
        default: begin step.dst = DST_FLAGS; step.last = 1'b1; end
      endcase
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (accept) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (state_q == ST_RUN) begin
      if (step.last) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_PHA;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) op_q <= cmd_op;
    end
  end

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step.last |=> !busy); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step.last |=> !step.last); // R11
  AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q)); // R1
endmodule

// File: rtl/stk_seq_ptr.sv
module stk_seq_ptr
  import stk_seq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] S_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pull,
  output logic [BYTE_W-1:0] s_q,
  output logic [BYTE_W-1:0] slot
);
  logic [BYTE_W-1:0] s_d;
  logic              s_en;

  assign slot = pull ? s_q + 1'b1 : s_q;
  assign s_en = push || pull;
  assign s_d  = push ? s_q - 1'b1 : s_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= S_RESET;
    else if (s_en) s_q <= s_d;
  end

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (s_q == $past(s_q) - 8'd1)); // R2
  AST_PULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    pull |=> (s_q == $past(s_q) + 8'd1)); // R2
  AST_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pull)); // R2
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [BYTE_W-1:0] S_RESET    = 8'hFF,
  parameter logic [WORD_W-1:0] VEC_ADDR   = 16'hFFFE,
  parameter int                BRK_BIT    = 4,
  parameter int                NEG_BIT    = 7,
  parameter int                ZERO_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] pc_in,
  input  logic [WORD_W-1:0] target,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [BYTE_W-1:0] p_in,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] pc_out,
  output logic [BYTE_W-1:0] p_out,
  output logic [BYTE_W-1:0] a_out,
  output logic [BYTE_W-1:0] s_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              accept;
  stk_op_e           op_q;
  step_t             step;
  logic              push, pull;
  logic [BYTE_W-1:0] slot;
  logic [WORD_W-1:0] pc_q, pc_d, tgt_q, ret_w;
  logic [BYTE_W-1:0] p_q, p_d, a_q, a_d, lo_q;
  logic              pc_en, p_en, a_en, lo_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  stk_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid),
    .cmd_op(stk_op_e'(cmd_op)), .accept(accept), .busy(busy),
    .op_q(op_q), .step(step)
  );

  assign push = step.act && step.wr && !step.vec;
  assign pull = step.act && !step.wr && !step.vec;

  stk_seq_ptr #(.S_RESET(S_RESET)) u_ptr (
    .clk(clk), .rst_n(rst_int_n), .push(push), .pull(pull),
    .s_q(s_out), .slot(slot)
  );

  assign done   = step.last;
  assign mem_we = step.act && step.wr;
  assign ret_w  = pc_q - {{(WORD_W-1){1'b0}}, (op_q == OP_JSR)};

  always_comb begin
    if (!step.act)     mem_addr = '0;
    else if (step.vec) mem_addr = {VEC_ADDR[WORD_W-1:1], step.vhi};
    else               mem_addr = {STACK_PAGE, slot};
  end

  always_comb begin
    unique case (step.src)
      SRC_RET_HI: mem_wdata = ret_w[WORD_W-1:BYTE_W];
      SRC_RET_LO: mem_wdata = ret_w[BYTE_W-1:0];
      SRC_FLAGS:  mem_wdata = p_q;
      SRC_ACC:    mem_wdata = a_q;
      default:    mem_wdata = '0;
    endcase
  end

  always_comb begin
    pc_en = accept; pc_d = pc_in;
    p_en  = accept; p_d  = p_in;
    a_en  = accept; a_d  = a_in;
    lo_en = 1'b0;
    if (step.act && !step.wr) begin
      unique case (step.dst)
        DST_PC_LO: lo_en = 1'b1;
        DST_PC_HI: begin
          pc_en = 1'b1;
          pc_d  = {mem_rdata, lo_q} + {{(WORD_W-1){1'b0}}, (op_q == OP_RTS)};
          if (op_q == OP_BRK) begin
            p_en         = 1'b1;
            p_d          = p_q;
            p_d[BRK_BIT] = 1'b1;
          end
        end
        DST_FLAGS: begin p_en = 1'b1; p_d = mem_rdata; end
        DST_ACC: begin
          a_en          = 1'b1;
          a_d           = mem_rdata;
          p_en          = 1'b1;
          p_d           = p_q;
          p_d[NEG_BIT]  = mem_rdata[BYTE_W-1];
          p_d[ZERO_BIT] = (mem_rdata == '0);
        end
        default: ;
      endcase
    end
    if (step.last && op_q == OP_JSR) begin
      pc_en = 1'b1;
      pc_d  = tgt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q  <= '0;
      tgt_q <= '0;
      p_q   <= '0;
      a_q   <= '0;
      lo_q  <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (accept) tgt_q <= target;
      if (p_en)   p_q   <= p_d;
      if (a_en)   a_q   <= a_d;
      if (lo_en)  lo_q  <= mem_rdata;
    end
  end

  assign pc_out = pc_q;
  assign p_out  = p_q;
  assign a_out  = a_q;

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> !mem_we); // R1
  AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we |-> (mem_addr[WORD_W-1:BYTE_W] == STACK_PAGE)); // R2
  AST_IDLE_S_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |=> $stable(s_out)); // R2
  AST_BRK_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && op_q == OP_BRK) |=> p_out[BRK_BIT]); // R10
  AST_JSR_TARGET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && op_q == OP_JSR) |=> (pc_out == $past(tgt_q))); // R7
endmodule

// File: tb/stk_seq_test.sv
module stk_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_BRK = 3'd0, C_JSR = 3'd1, C_RTS = 3'd2, C_RTI = 3'd3,
                         C_PHA = 3'd4, C_PHP = 3'd5, C_PLA = 3'd6, C_PLP = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] pc_in = '0, target = '0;
  logic [7:0]  a_in = '0, p_in = '0;
  logic        busy, done, mem_we;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, mem_rdata, p_out, a_out, s_out;

  logic [7:0]  stk [0:255];
  logic [7:0]  vlo = 8'h78, vhi = 8'h56;
  logic [15:0] wa [0:7];
  logic [7:0]  wd [0:7];
  int          wn = 0;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pc_in(pc_in), .target(target), .a_in(a_in), .p_in(p_in),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .pc_out(pc_out), .p_out(p_out),
    .a_out(a_out), .s_out(s_out)
  );

  assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                     (mem_addr == 16'hFFFE) ? vlo :
                     (mem_addr == 16'hFFFF) ? vhi : 8'h00;

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
      if (wn < 8) begin
        wa[wn] = mem_addr;
        wd[wn] = mem_wdata;
      end
      wn = wn + 1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [15:0] pc, input logic [15:0] tgt,
                     input logic [7:0] a, input logic [7:0] p, input bit hold,
                     output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; pc_in = pc; target = tgt; a_in = a; p_in = p;
    wn = 0;
    @(posedge clk);
    @(negedge clk);
    cyc = 0;
    for (int i = 0; i < 16; i++) begin
      cyc++;
      if (done) begin
        cmd_valid = 1'b0;
        break;
      end
      cmd_valid = hold;
      if (hold) begin cmd_op = C_PLA; a_in = 8'hEE; end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 reset S", {8'h00, s_out}, 16'h00FF);
    chk("R11 reset busy", {15'd0, busy}, 16'd0);
    chk("R11 reset done", {15'd0, done}, 16'd0);
    chk("R1 reset we", {15'd0, mem_we}, 16'd0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 idle no write", {15'd0, mem_we}, 16'd0);
      chk("R1 idle S", {8'h00, s_out}, 16'h00FF);
    end
  endtask

  task automatic t_wrap;
    int c;
    stk[0] = 8'h5A;
    run(C_PLA, 16'h0, 16'h0, 8'h00, 8'h00, 1'b0, c);
    chk("R2 pull wrap S", {8'h00, s_out}, 16'h0000);
    chk("R2 pull wrap data", {8'h00, a_out}, 16'h005A);
    chk("R11 PLA cycles", 16'(c), 16'd1);
    run(C_PHA, 16'h0, 16'h0, 8'h11, 8'h00, 1'b0, c);
    chk("R3 PHA writes", 16'(wn), 16'd1);
    chk("R2 push addr at S=00", wa[0], 16'h0100);
    chk("R3 PHA data", {8'h00, wd[0]}, 16'h0011);
    chk("R2 push wrap S", {8'h00, s_out}, 16'h00FF);
  endtask

  task automatic t_call_ret;
    int c;
    run(C_JSR, 16'h1234, 16'h8000, 8'h00, 8'h00, 1'b0, c);
    chk("R7 JSR writes", 16'(wn), 16'd2);
    chk("R7 JSR hi addr", wa[0], 16'h01FF);
    chk("R7 JSR hi data", {8'h00, wd[0]}, 16'h0012);
    chk("R7 JSR lo addr", wa[1], 16'h01FE);
    chk("R7 JSR lo data", {8'h00, wd[1]}, 16'h0033);
    chk("R7 JSR PC", pc_out, 16'h8000);
    chk("R7 JSR S", {8'h00, s_out}, 16'h00FD);
    chk("R11 JSR cycles", 16'(c), 16'd2);
    run(C_RTS, 16'h8000, 16'h0, 8'h00, 8'h00, 1'b0, c);
    chk("R8 RTS PC", pc_out, 16'h1234);
    chk("R8 RTS S", {8'h00, s_out}, 16'h00FF);
    chk("R8 RTS no write", 16'(wn), 16'd0);
    chk("R11 RTS cycles", 16'(c), 16'd2);
  endtask

  task automatic t_rts_wrap;
    int c;
    run(C_PHA, 16'h0, 16'h0, 8'hFF, 8'h00, 1'b0, c);
    run(C_PHA, 16'h0, 16'h0, 8'hFF, 8'h00, 1'b0, c);
    run(C_RTS, 16'h4000, 16'h0, 8'h00, 8'h00, 1'b0, c);
    chk("R8 RTS 16-bit wrap", pc_out, 16'h0000);
  endtask

  task automatic t_pulls;
    int c;
    run(C_PHA, 16'h0, 16'h0, 8'h80, 8'h00, 1'b0, c);
    run(C_PLA, 16'h0, 16'h0, 8'h00, 8'h02, 1'b0, c);
    chk("R5 PLA neg A", {8'h00, a_out}, 16'h0080);
    chk("R5 PLA neg flags", {8'h00, p_out}, 16'h0080);
    run(C_PHA, 16'h0, 16'h0, 8'h00, 8'h00, 1'b0, c);
    run(C_PLA, 16'h0, 16'h0, 8'h55, 8'h81, 1'b0, c);
    chk("R5 PLA zero A", {8'h00, a_out}, 16'h0000);
    chk("R5 PLA zero flags", {8'h00, p_out}, 16'h0003);
    run(C_PHA, 16'h0, 16'h0, 8'hC3, 8'h00, 1'b0, c);
    run(C_PLP, 16'h0, 16'h0, 8'h00, 8'h00, 1'b0, c);
    chk("R6 PLP flags", {8'h00, p_out}, 16'h00C3);
    chk("R11 PLP cycles", 16'(c), 16'd1);
    run(C_PHP, 16'h0, 16'h0, 8'h00, 8'h5A, 1'b0, c);
    chk("R4 PHP addr", wa[0], 16'h01FF);
    chk("R4 PHP data", {8'h00, wd[0]}, 16'h005A);
    run(C_PLP, 16'h0, 16'h0, 8'h00, 8'h00, 1'b0, c);
    chk("R6 PLP back", {8'h00, p_out}, 16'h005A);
    chk("R2 S after pulls", {8'h00, s_out}, 16'h00FF);
  endtask

  task automatic t_brk_rti;
    int c;
    run(C_BRK, 16'hABCD, 16'h0, 8'h00, 8'h01, 1'b0, c);
    chk("R10 BRK writes", 16'(wn), 16'd3);
    chk("R10 BRK hi", {wa[0][7:0], wd[0]}, 16'hFFAB);
    chk("R10 BRK lo", {wa[1][7:0], wd[1]}, 16'hFECD);
    chk("R10 BRK flags", {wa[2][7:0], wd[2]}, 16'hFD01);
    chk("R10 BRK vector PC", pc_out, 16'h5678);
    chk("R10 BRK flag bit4", {8'h00, p_out}, 16'h0011);
    chk("R10 BRK S", {8'h00, s_out}, 16'h00FC);
    chk("R11 BRK cycles", 16'(c), 16'd5);
    run(C_RTI, 16'h5678, 16'h0, 8'h00, 8'h11, 1'b0, c);
    chk("R9 RTI PC no inc", pc_out, 16'hABCD);
    chk("R9 RTI flags", {8'h00, p_out}, 16'h0001);
    chk("R9 RTI S", {8'h00, s_out}, 16'h00FF);
    chk("R11 RTI cycles", 16'(c), 16'd3);
  endtask

  task automatic t_busy_ignore;
    int c;
    run(C_JSR, 16'h2000, 16'h3000, 8'h77, 8'h00, 1'b1, c);
    chk("R1 busy ignore writes", 16'(wn), 16'd2);
    chk("R1 busy ignore A", {8'h00, a_out}, 16'h0077);
    chk("R1 busy ignore S", {8'h00, s_out}, 16'h00FD);
    chk("R1 busy ignore PC", pc_out, 16'h3000);
    chk("R11 idle after done", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R1 no restart", {8'h00, s_out}, 16'h00FD);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_wrap();
    t_call_ret();
    t_rts_wrap();
    t_pulls();
    t_brk_rti();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule